// File: doc/BRIEF.md
# Strobed 4x4 Matrix Keypad Scanner

This block connects a 4x4 switch matrix to a controller. It has four active-low column drive outputs and four active-low row sense inputs with pull-ups. Between scans it drives every column low. Pressing any key then pulls at least one row low. The rows pass through a two-stage synchronizer, and a falling edge on the combined "all rows high" signal raises a strobe request.

After the strobe, the press must stay present for a programmable number of scan ticks. The scanner then drives one column low at a time, lowest column first, and samples the rows. The first column that shows a low row ends the scan. The result is presented as an 8-bit raw code and a 4-bit key index. The result stays valid until the controller acknowledges it. Once acknowledged, the scanner waits for all rows to return high before it accepts another press.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, all four column outputs are low and `key_valid` is 0.
- R2: While no scan is in progress, all column outputs stay at 4'b0000. A press of any key then produces a strobe request, and a scan result follows without any other input.
- R3: A press is accepted only after the rows have stayed low for DEB_TICKS scan ticks, where one tick is TICK_DIV clock cycles. A row low pulse shorter than TICK_DIV cycles produces no report.
- R4: During a scan, exactly one column output is low and the other three are high. Columns are visited in the order 0, 1, 2, 3, and column c is driven low on bit c of `col_n`.
- R5: The raw code puts the sampled rows in bits [7:4], with row r on bit 4+r and a pressed row reading 0. It puts the driven column pattern in bits [3:0], where the scanned column is the only 0. For example, row 1 in column 0 gives 8'hDE.
- R6: The key index is row*4+col, where row is the lowest-numbered low row in the reporting column.
- R7: When keys in several columns are held, the lowest-numbered column that shows a low row is reported.
- R8: `key_valid`, `key_raw` and `key_idx` hold steady until `key_ack` is seen high. `key_valid` is 0 one cycle after that.
- R9: After an acknowledge, no new scan starts and no new report is made until all rows have been seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n | input | 4 | Row sense lines, active low, asynchronous |
| key_ack | input | 1 | Controller acknowledge of the presented result |
| col_n | output | 4 | Column drive lines, active low |
| key_valid | output | 1 | A result is presented |
| key_raw | output | 8 | Raw code: rows in [7:4], column pattern in [3:0] |
| key_idx | output | 4 | Key index, row*4+col |

## Verification
The bench builds the scanner with TICK_DIV=4 and DEB_TICKS=3. With these values a full debounce lasts about a dozen cycles, so every key position, multi-key presses and a short glitch fit in a few hundred cycles each. The keypad model turns the column drive into row levels combinationally. This lets the bench watch the column sequence of a scan reaching column 3, and show that a 3-cycle glitch is rejected. It also holds a key after acknowledge for long enough to show that no rescan happens.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int KP_COLS = 4;
  localparam int KP_ROWS = 4;
  localparam int COL_W   = $clog2(KP_COLS);
  localparam int ROW_W   = $clog2(KP_ROWS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEBOUNCE,
    ST_SCAN,
    ST_REPORT,
    ST_RELEASE
  } kpd_state_t;

  // Active-low drive pattern for one column
  function automatic logic [KP_COLS-1:0] col_drive(input logic [COL_W-1:0] col);
    logic [KP_COLS-1:0] pat;
    pat = '1;
    pat[col] = 1'b0;
    return pat;
  endfunction

  // Lowest-numbered low row
  function automatic logic [ROW_W-1:0] first_low_row(input logic [KP_ROWS-1:0] rows);
    logic [ROW_W-1:0] r;
    r = '0;
    for (int i = KP_ROWS - 1; i >= 0; i--)
      if (!rows[i]) r = ROW_W'(i);
    return r;
  endfunction

  function automatic logic [7:0] form_raw(input logic [KP_ROWS-1:0] rows,
                                          input logic [COL_W-1:0] col);
    return {rows, col_drive(col)};
  endfunction

  function automatic logic [ROW_W+COL_W-1:0] key_index(input logic [ROW_W-1:0] row,
                                                        input logic [COL_W-1:0] col);
    return {row, col};
  endfunction
endpackage

// File: rtl/kpd_row_sync.sv
module kpd_row_sync #(
  parameter int NROWS  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NROWS-1:0] row_n,
  output logic [NROWS-1:0] rows_s,
  output logic             any_low,
  output logic             strobe_req
);
  logic [NROWS-1:0] stage [STAGES];
  logic             any_low_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= '1;
          else        stage[s] <= row_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[s] <= '1;
          else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign rows_s  = stage[STAGES-1];
  assign any_low = ~&rows_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) any_low_q <= 1'b0;
    else        any_low_q <= any_low;

  assign strobe_req = any_low & ~any_low_q;

  // R2
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_req |=> !strobe_req);
endmodule

// File: rtl/kpd_tick_gen.sv
module kpd_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;

  assign tick = (cnt == LAST);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/kpd_scan_fsm.sv
module kpd_scan_fsm
  import kpd_pkg::*;
#(
  parameter int DEB_TICKS  = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KP_ROWS-1:0] rows_s,
  input  logic               any_low,
  input  logic               strobe_req,
  input  logic               tick,
  input  logic               key_ack,
  output logic [KP_COLS-1:0] col_n,
  output logic               key_valid,
  output logic [7:0]         key_raw,
  output logic [3:0]         key_idx
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [DW-1:0]    DEB_LAST = DW'(DEB_TICKS - 1);
  localparam logic [SW-1:0]    SET_LAST = SW'(SETTLE_CYC - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(KP_COLS - 1);

  kpd_state_t       state;
  logic [COL_W-1:0] col;
  logic [DW-1:0]    deb_cnt;
  logic [SW-1:0]    settle_cnt;

  // Named internal events
  logic settle_done, hit, deb_done, all_high;
  assign settle_done = (state == ST_SCAN) && (settle_cnt == SET_LAST);
  assign hit         = settle_done && any_low;
  assign deb_done    = (state == ST_DEBOUNCE) && any_low && tick && (deb_cnt == DEB_LAST);
  assign all_high    = &rows_s;

  assign col_n = (state == ST_SCAN) ? col_drive(col) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      col        <= '0;
      deb_cnt    <= '0;
      settle_cnt <= '0;
      key_valid  <= 1'b0;
      key_raw    <= '0;
      key_idx    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe_req) begin
            state   <= ST_DEBOUNCE;
            deb_cnt <= '0;
          end
        end
        ST_DEBOUNCE: begin
          if (!any_low) begin
            state <= ST_IDLE;
          end else if (deb_done) begin
            state      <= ST_SCAN;
            col        <= '0;
            settle_cnt <= '0;
          end else if (tick) begin
            deb_cnt <= deb_cnt + 1'b1;
          end
        end
        ST_SCAN: begin
          if (!settle_done) begin
            settle_cnt <= settle_cnt + 1'b1;
          end else if (hit) begin
            key_raw   <= form_raw(rows_s, col);
            key_idx   <= key_index(first_low_row(rows_s), col);
            key_valid <= 1'b1;
            state     <= ST_REPORT;
          end else if (col == COL_LAST) begin
            state <= ST_RELEASE;
          end else begin
            col        <= col + 1'b1;
            settle_cnt <= '0;
          end
        end
        ST_REPORT: begin
          if (key_ack) begin
            key_valid <= 1'b0;
            state     <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (all_high) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_ack |=> key_valid && $stable(key_raw) && $stable(key_idx));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ack |=> !key_valid);
  // R5
  raw_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ($countones(key_raw[3:0]) == 3) && (key_raw[7:4] != 4'hF));
  // R4
  scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_n != '0) |-> ($countones(col_n) == KP_COLS - 1));
  // R2
  report_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (col_n == '0));
  // R3
  deb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deb_cnt <= DEB_LAST);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE) && !all_high |=> (state == ST_RELEASE));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int TICK_DIV    = 1000,
  parameter int DEB_TICKS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] row_n,
  input  logic       key_ack,
  output logic [3:0] col_n,
  output logic       key_valid,
  output logic [7:0] key_raw,
  output logic [3:0] key_idx
);
  import kpd_pkg::*;

  localparam int SETTLE_CYC = SYNC_STAGES + 2;

  logic [KP_ROWS-1:0] rows_s;
  logic               any_low;
  logic               strobe_req;
  logic               scan_tick;

  kpd_row_sync #(.NROWS(KP_ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .row_n(row_n),
    .rows_s(rows_s), .any_low(any_low), .strobe_req(strobe_req)
  );

  kpd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick)
  );

  kpd_scan_fsm #(.DEB_TICKS(DEB_TICKS), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rows_s(rows_s), .any_low(any_low),
    .strobe_req(strobe_req), .tick(scan_tick), .key_ack(key_ack),
    .col_n(col_n), .key_valid(key_valid), .key_raw(key_raw), .key_idx(key_idx)
  );
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic       key_ack = 1'b0;
  logic [3:0] col_n;
  logic       key_valid;
  logic [7:0] key_raw;
  logic [3:0] key_idx;
  logic [15:0] press = '0;   // bit r*4+c = key at row r, column c

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keypad_scanner #(.TICK_DIV(4), .DEB_TICKS(3), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .key_ack(key_ack),
    .col_n(col_n), .key_valid(key_valid), .key_raw(key_raw), .key_idx(key_idx)
  );

  // Passive keypad: a row is low when a pressed key sits on a low column
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < 4; c++)
        if (press[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
    end
  end

  // Column sequence monitor
  logic [3:0] seq [8];
  int         nseq = 0;
  logic [3:0] last_cols = 4'h0;
  always @(negedge clk) begin
    if (rst_n && col_n != 4'h0 && col_n != last_cols) begin
      if (nseq < 8) seq[nseq] = col_n;
      nseq = nseq + 1;
      if (col_n != 4'hE && col_n != 4'hD && col_n != 4'hB && col_n != 4'h7) begin
        n_chk++; n_fail++;
        $display("FAIL R4 scan pattern act=%h exp=one low column", col_n);
      end
    end
    last_cols = col_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (key_valid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic do_ack();
    key_ack = 1'b1;
    @(negedge clk);
    key_ack = 1'b0;
  endtask

  // {press mask, raw, idx, pad}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0001, 8'hEE, 4'd0,  4'h0},
    {16'h0010, 8'hDE, 4'd4,  4'h0},
    {16'h1000, 8'h7E, 4'd12, 4'h0},
    {16'h0002, 8'hED, 4'd1,  4'h0},
    {16'h0200, 8'hBD, 4'd9,  4'h0},
    {16'h0040, 8'hDB, 4'd6,  4'h0},
    {16'h8000, 8'h77, 4'd15, 4'h0},
    {16'h0800, 8'hB7, 4'd11, 4'h0},
    {16'h0208, 8'hBD, 4'd9,  4'h0},
    {16'h4040, 8'h5B, 4'd6,  4'h0}
  };

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(col_n == 4'h0, "R1 cols in reset", col_n, 0);
    check(key_valid == 1'b0, "R1 valid in reset", key_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(col_n == 4'h0, "R2 idle cols", col_n, 0);

    for (int v = 0; v < NV; v++) begin
      nseq = 0;
      press = VEC[v][31:16];
      wait_valid(500, seen);
      check(seen, "R2 report after press", seen, 1);
      check(key_raw == VEC[v][15:8], "R5 raw code", key_raw, VEC[v][15:8]);
      check(key_idx == VEC[v][7:4], "R6 key index", key_idx, VEC[v][7:4]);
      if (VEC[v][31:16] == 16'h8000) begin
        check(nseq == 4, "R4 scan steps", nseq, 4);
        check(seq[0] == 4'hE && seq[1] == 4'hD && seq[2] == 4'hB && seq[3] == 4'h7,
              "R4 scan order", {seq[0], seq[1], seq[2], seq[3]}, 16'hEDB7);
      end
      if (VEC[v][31:16] == 16'h0208)
        check(key_idx == 4'd9, "R7 first column wins", key_idx, 9);
      repeat (20) @(negedge clk);
      check(key_valid && key_raw == VEC[v][15:8], "R8 held until ack", key_raw, VEC[v][15:8]);
      do_ack();
      check(!key_valid, "R8 cleared after ack", key_valid, 0);
      press = '0;
      repeat (30) @(negedge clk);
    end

    // R9: keep key held after ack; no rescan, no report
    press = 16'h0001;
    wait_valid(500, seen);
    check(seen, "R9 first report", seen, 1);
    do_ack();
    nseq = 0;
    repeat (200) @(negedge clk);
    check(!key_valid, "R9 no report while held", key_valid, 0);
    check(nseq == 0 && col_n == 4'h0, "R9 no rescan while held", nseq, 0);
    press = '0;
    repeat (20) @(negedge clk);
    press = 16'h0004;
    wait_valid(500, seen);
    check(seen && key_idx == 4'd2, "R9 report after release", key_idx, 2);
    do_ack();
    press = '0;
    repeat (30) @(negedge clk);

    // R3: glitch shorter than one tick is rejected
    press = 16'h0001;
    repeat (3) @(negedge clk);
    press = '0;
    repeat (100) @(negedge clk);
    check(!key_valid, "R3 glitch rejected", key_valid, 0);
    check(col_n == 4'h0, "R2 idle after glitch", col_n, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule